// File: doc/BRIEF.md
# Rename Undo and Retire Log

This block keeps an ordered record of the register renames made by a rename stage, so that speculative mappings can later be rolled back or retired. For each destination it renames, the rename stage pushes one record holding the instruction's sequence number, the architectural register, the physical register just allocated and the physical register that the architectural register was mapped to before. An instruction that writes no register pushes a single placeholder record that carries only its sequence number.

A squash request names the youngest sequence number that survives. The block walks back from the newest record and removes every younger record. For each removed record it restores the old mapping in the external map table and returns the newly allocated register to the external free list. A commit request names a retired sequence number. The block walks forward from the oldest record and removes every record up to and including that number, returning each record's previous physical register to the free list. Both walks process one record per cycle. While a walk runs, `busy_o` is high and pushes are not taken.

Top module: `rename_undo_log`

## Requirements
- R1: After reset the log is empty, and `busy_o`, `full_o`, `map_we_o` and `free_we_o` are low. A push taken while idle, with no squash or commit request in the same cycle and the log not full, stores one record at the newest end and produces no write.
- R2: `full_o` is high exactly when the log holds DEPTH records. A push offered while the log is full is dropped and leaves the log contents unchanged.
- R3: A push offered while `busy_o` is high is dropped. A push offered in the same cycle as a squash or commit request is also dropped.
- R4: Squash of S removes records newest-first while the newest record's sequence number is greater than S, at one record per cycle. For each such record that is not a placeholder, one cycle carries a map write (architectural register to previous physical register) together with a free-list write of the new physical register.
- R5: Placeholder records are removed like any other record but produce neither a map write nor a free-list write, whether they are removed by squash or by commit.
- R6: Commit of N removes records oldest-first while the oldest record's sequence number is at most N, at one record per cycle. This includes every record of a multi-destination instruction. Each non-placeholder record gives one free-list write of its previous physical register and no map write.
- R7: A commit whose N is less than the oldest held sequence number is ignored, and so is a commit or squash while the log is empty. An ignored request leaves `busy_o` low, produces no writes and removes nothing.
- R8: When squash and commit are requested in the same idle cycle, the squash is performed and the commit is ignored.
- R9: An accepted request raises `busy_o` on the cycle after it is sampled. Writes appear on the following cycles, one record per cycle. `busy_o` stays high for exactly (records removed + 1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid_i | input | 1 | Offer one record from rename |
| push_seq_i | input | SEQ_W | Sequence number of the record |
| push_arch_i | input | AREG_W | Architectural destination register |
| push_new_i | input | PREG_W | Newly allocated physical register |
| push_prev_i | input | PREG_W | Physical register previously mapped |
| push_hold_i | input | 1 | Record is a placeholder (no destination) |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Youngest surviving sequence number |
| commit_valid_i | input | 1 | Commit request |
| commit_seq_i | input | SEQ_W | Retired sequence number |
| busy_o | output | 1 | A squash or commit walk is in progress |
| full_o | output | 1 | Log holds DEPTH records |
| map_we_o | output | 1 | Map-table restore write strobe |
| map_arch_o | output | AREG_W | Architectural register to restore |
| map_phys_o | output | PREG_W | Physical register restored into the map |
| free_we_o | output | 1 | Free-list return strobe |
| free_phys_o | output | PREG_W | Physical register returned to the free list |

## Verification
The bench cannot read the log directly, so the bench brings any stored state out through later walks. A wrong pointer or count appears as a wrong register pair, or as a missing or extra write, during the next squash or commit. That is at most DEPTH+1 cycles after the faulty cycle. A dropped or duplicated push shows up as a changed number of free-list returns when the log is drained. A wrong stop condition shows up at once as a wrong length of the `busy_o` window.

// File: rtl/rul_pkg.sv
package rul_pkg;
  // Walk state of the controller
  typedef enum logic [1:0] {
    WK_IDLE   = 2'd0,
    WK_UNDO   = 2'd1,
    WK_RETIRE = 2'd2
  } walk_e;
endpackage

// File: rtl/rul_ring.sv
module rul_ring #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_new_i,
  input  logic             pop_old_i,
  output logic [WIDTH-1:0] newest_o,
  output logic [WIDTH-1:0] oldest_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] step_up(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] step_down(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  // storage: write port only, no reset, so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_i) mem[head_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i)    head_q <= step_up(head_q);
      if (pop_new_i) head_q <= step_down(head_q);
      if (pop_old_i) tail_q <= step_up(tail_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_new_i) - CNT_W'(pop_old_i);
    end
  end

  assign newest_o = mem[step_down(head_q)];
  assign oldest_o = mem[tail_q];
  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) cnt_q <= CNT_W'(DEPTH)); // R2
  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (rst) push_i |-> !full_o); // R2
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst) (pop_new_i || pop_old_i) |-> !empty_o); // R4
  AST_ONE_OP: assert property (@(posedge clk) disable iff (rst) $countones({push_i, pop_new_i, pop_old_i}) <= 1); // R3
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst) push_i |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
endmodule

// File: rtl/rul_walk.sv
module rul_walk
  import rul_pkg::*;
#(
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7,
  localparam int E_W   = SEQ_W + AREG_W + 2 * PREG_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid_i,
  input  logic              squash_valid_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  input  logic              commit_valid_i,
  input  logic [SEQ_W-1:0]  commit_seq_i,
  input  logic              empty_i,
  input  logic              full_i,
  input  logic [E_W-1:0]    newest_i,
  input  logic [E_W-1:0]    oldest_i,
  output logic              push_en_o,
  output logic              pop_new_o,
  output logic              pop_old_o,
  output logic              busy_o,
  output logic              map_we_o,
  output logic [AREG_W-1:0] map_arch_o,
  output logic [PREG_W-1:0] map_phys_o,
  output logic              free_we_o,
  output logic [PREG_W-1:0] free_phys_o
);
  // record layout: {hold, seq, arch, new, prev}
  localparam int PREV_LO = 0;
  localparam int NEW_LO  = PREG_W;
  localparam int ARCH_LO = 2 * PREG_W;
  localparam int SEQ_LO  = ARCH_LO + AREG_W;
  localparam int HOLD_B  = SEQ_LO + SEQ_W;

  walk_e            state_q;
  logic [SEQ_W-1:0] tgt_q;

  logic              n_hold, o_hold;
  logic [SEQ_W-1:0]  n_seq, o_seq;
  logic [AREG_W-1:0] n_arch;
  logic [PREG_W-1:0] n_new, n_prev, o_prev;
  logic              idle, undo_go, retire_go;

  assign n_hold = newest_i[HOLD_B];
  assign n_seq  = newest_i[SEQ_LO +: SEQ_W];
  assign n_arch = newest_i[ARCH_LO +: AREG_W];
  assign n_new  = newest_i[NEW_LO +: PREG_W];
  assign n_prev = newest_i[PREV_LO +: PREG_W];
  assign o_hold = oldest_i[HOLD_B];
  assign o_seq  = oldest_i[SEQ_LO +: SEQ_W];
  assign o_prev = oldest_i[PREV_LO +: PREG_W];

  assign idle      = (state_q == WK_IDLE);
  assign undo_go   = idle && squash_valid_i && !empty_i;
  assign retire_go = idle && !squash_valid_i && commit_valid_i && !empty_i
                     && (o_seq <= commit_seq_i);
  assign push_en_o = idle && push_valid_i && !squash_valid_i && !commit_valid_i && !full_i;
  assign pop_new_o = (state_q == WK_UNDO) && !empty_i && (n_seq > tgt_q);
  assign pop_old_o = (state_q == WK_RETIRE) && !empty_i && (o_seq <= tgt_q);
  assign busy_o    = !idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= WK_IDLE;
      tgt_q       <= '0;
      map_we_o    <= 1'b0;
      map_arch_o  <= '0;
      map_phys_o  <= '0;
      free_we_o   <= 1'b0;
      free_phys_o <= '0;
    end else begin
      map_we_o    <= pop_new_o && !n_hold;
      map_arch_o  <= n_arch;
      map_phys_o  <= n_prev;
      free_we_o   <= (pop_new_o && !n_hold) || (pop_old_o && !o_hold);
      free_phys_o <= pop_new_o ? n_new : o_prev;
      unique case (state_q)
        WK_IDLE: begin
          if (undo_go) begin
            state_q <= WK_UNDO;
            tgt_q   <= squash_seq_i;
          end else if (retire_go) begin
            state_q <= WK_RETIRE;
            tgt_q   <= commit_seq_i;
          end
        end
        WK_UNDO:   if (!pop_new_o) state_q <= WK_IDLE;
        WK_RETIRE: if (!pop_old_o) state_q <= WK_IDLE;
        default:   state_q <= WK_IDLE;
      endcase
    end
  end

  AST_MAP_IN_WALK: assert property (@(posedge clk) disable iff (rst) map_we_o |-> busy_o); // R9
  AST_FREE_IN_WALK: assert property (@(posedge clk) disable iff (rst) free_we_o |-> busy_o); // R9
  AST_MAP_WITH_FREE: assert property (@(posedge clk) disable iff (rst) map_we_o |-> free_we_o); // R4
  AST_RETIRE_NO_MAP: assert property (@(posedge clk) disable iff (rst) (state_q == WK_RETIRE) |=> !map_we_o); // R6
  AST_OLD_COMMIT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (idle && !squash_valid_i && commit_valid_i && !empty_i && (o_seq > commit_seq_i)) |=> !busy_o); // R7
endmodule

// File: rtl/rename_undo_log.sv
module rename_undo_log #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid_i,
  input  logic [SEQ_W-1:0]  push_seq_i,
  input  logic [AREG_W-1:0] push_arch_i,
  input  logic [PREG_W-1:0] push_new_i,
  input  logic [PREG_W-1:0] push_prev_i,
  input  logic              push_hold_i,
  input  logic              squash_valid_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  input  logic              commit_valid_i,
  input  logic [SEQ_W-1:0]  commit_seq_i,
  output logic              busy_o,
  output logic              full_o,
  output logic              map_we_o,
  output logic [AREG_W-1:0] map_arch_o,
  output logic [PREG_W-1:0] map_phys_o,
  output logic              free_we_o,
  output logic [PREG_W-1:0] free_phys_o
);
  localparam int E_W = SEQ_W + AREG_W + 2 * PREG_W + 1;

  logic           push_en, pop_new, pop_old, empty;
  logic [E_W-1:0] newest, oldest, rec_in;

  assign rec_in = {push_hold_i, push_seq_i, push_arch_i, push_new_i, push_prev_i};

  rul_ring #(.DEPTH(DEPTH), .WIDTH(E_W)) ring_i (
    .clk(clk), .rst(rst),
    .push_i(push_en), .push_data_i(rec_in),
    .pop_new_i(pop_new), .pop_old_i(pop_old),
    .newest_o(newest), .oldest_o(oldest),
    .empty_o(empty), .full_o(full_o)
  );

  rul_walk #(.SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)) walk_i (
    .clk(clk), .rst(rst),
    .push_valid_i(push_valid_i),
    .squash_valid_i(squash_valid_i), .squash_seq_i(squash_seq_i),
    .commit_valid_i(commit_valid_i), .commit_seq_i(commit_seq_i),
    .empty_i(empty), .full_i(full_o),
    .newest_i(newest), .oldest_i(oldest),
    .push_en_o(push_en), .pop_new_o(pop_new), .pop_old_o(pop_old),
    .busy_o(busy_o),
    .map_we_o(map_we_o), .map_arch_o(map_arch_o), .map_phys_o(map_phys_o),
    .free_we_o(free_we_o), .free_phys_o(free_phys_o)
  );
endmodule

// File: tb/rename_undo_log_tb.sv
module rename_undo_log_tb_top;
  localparam int DEPTH = 8, SEQ_W = 16, AREG_W = 5, PREG_W = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic push_valid, push_hold, squash_valid, commit_valid;
  logic [SEQ_W-1:0] push_seq, squash_seq, commit_seq;
  logic [AREG_W-1:0] push_arch;
  logic [PREG_W-1:0] push_new, push_prev;
  logic busy, full, map_we, free_we;
  logic [AREG_W-1:0] map_arch;
  logic [PREG_W-1:0] map_phys, free_phys;

  rename_undo_log #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)) dut_i (
    .clk(clk), .rst(rst),
    .push_valid_i(push_valid), .push_seq_i(push_seq), .push_arch_i(push_arch),
    .push_new_i(push_new), .push_prev_i(push_prev), .push_hold_i(push_hold),
    .squash_valid_i(squash_valid), .squash_seq_i(squash_seq),
    .commit_valid_i(commit_valid), .commit_seq_i(commit_seq),
    .busy_o(busy), .full_o(full),
    .map_we_o(map_we), .map_arch_o(map_arch), .map_phys_o(map_phys),
    .free_we_o(free_we), .free_phys_o(free_phys)
  );

  int n_chk = 0, n_fail = 0;
  // bench model of the log, newest at the back
  int m_seq[$], m_arch[$], m_new[$], m_prev[$];
  bit m_ph[$];
  int e_ma[$], e_mp[$], e_f[$], g_ma[$], g_mp[$], g_f[$];
  int busy_cycles;

  function automatic int arch_of(int s); return s % 32; endfunction
  function automatic int new_of(int s);  return (s * 3 + 2) % 128; endfunction
  function automatic int prev_of(int s); return (s * 5 + 1) % 128; endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_one(int s, bit ph);
    @(negedge clk);
    push_valid = 1'b1; push_seq = SEQ_W'(s); push_hold = ph;
    push_arch = AREG_W'(arch_of(s)); push_new = PREG_W'(new_of(s)); push_prev = PREG_W'(prev_of(s));
    if (!busy && m_seq.size() < DEPTH) begin
      m_seq.push_back(s); m_arch.push_back(arch_of(s)); m_new.push_back(new_of(s));
      m_prev.push_back(prev_of(s)); m_ph.push_back(ph);
    end
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  // expected outcome of a request, from the requirements
  task automatic model(bit sq, int s, bit cm, int c, output bit acc, output int pops);
    acc = 1'b0; pops = 0;
    e_ma.delete(); e_mp.delete(); e_f.delete();
    if (sq) begin
      if (m_seq.size() == 0) return;
      acc = 1'b1;
      while (m_seq.size() > 0 && m_seq[$] > s) begin
        if (!m_ph[$]) begin
          e_ma.push_back(m_arch[$]); e_mp.push_back(m_prev[$]); e_f.push_back(m_new[$]);
        end
        void'(m_seq.pop_back()); void'(m_arch.pop_back()); void'(m_new.pop_back());
        void'(m_prev.pop_back()); void'(m_ph.pop_back());
        pops++;
      end
    end else if (cm) begin
      if (m_seq.size() == 0 || m_seq[0] > c) return;
      acc = 1'b1;
      while (m_seq.size() > 0 && m_seq[0] <= c) begin
        if (!m_ph[0]) e_f.push_back(m_prev[0]);
        void'(m_seq.pop_front()); void'(m_arch.pop_front()); void'(m_new.pop_front());
        void'(m_prev.pop_front()); void'(m_ph.pop_front());
        pops++;
      end
    end
  endtask

  // issue a request, collect the writes, compare with the model
  task automatic run_req(string req, bit sq, int s, bit cm, int c, bit pb, int pbs);
    bit acc;
    int pops;
    g_ma.delete(); g_mp.delete(); g_f.delete(); busy_cycles = 0;
    @(negedge clk);
    squash_valid = sq; squash_seq = SEQ_W'(s); commit_valid = cm; commit_seq = SEQ_W'(c);
    model(sq, s, cm, c, acc, pops);
    for (int i = 0; i < 4 * DEPTH + 8; i++) begin
      @(posedge clk); #1;
      if (map_we) begin g_ma.push_back(int'(map_arch)); g_mp.push_back(int'(map_phys)); end
      if (free_we) g_f.push_back(int'(free_phys));
      if (i == 0) begin
        squash_valid = 1'b0; commit_valid = 1'b0;
        if (pb) begin  // offered while busy is high: must be dropped
          push_valid = 1'b1; push_seq = SEQ_W'(pbs); push_hold = 1'b0;
          push_arch = AREG_W'(arch_of(pbs)); push_new = PREG_W'(new_of(pbs));
          push_prev = PREG_W'(prev_of(pbs));
        end
      end else push_valid = 1'b0;
      if (!busy) break;
      busy_cycles++;
    end
    push_valid = 1'b0;
    check(req, "map write count", g_ma.size(), e_ma.size());
    check(req, "free write count", g_f.size(), e_f.size());
    for (int k = 0; k < e_ma.size() && k < g_ma.size(); k++) begin
      check(req, "map arch", g_ma[k], e_ma[k]);
      check(req, "map phys", g_mp[k], e_mp[k]);
    end
    for (int k = 0; k < e_f.size() && k < g_f.size(); k++)
      check(req, "free phys", g_f[k], e_f[k]);
    check("R9", "busy cycles", busy_cycles, acc ? pops + 1 : 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "full after reset", int'(full), 0);
    check("R1", "map_we after reset", int'(map_we), 0);
    check("R1", "free_we after reset", int'(free_we), 0);
  endtask

  task automatic t_squash_basic();
    push_one(1, 0); push_one(2, 0); push_one(3, 1); push_one(4, 0);
    check("R1", "no map write on push", int'(map_we), 0);
    check("R1", "full after 4 pushes", int'(full), 0);
    run_req("R4 R5 squash newest-first", 1, 2, 0, 0, 0, 0);
  endtask

  task automatic t_commit();
    run_req("R7 commit older than oldest", 0, 0, 1, 0, 0, 0);
    run_req("R6 commit single", 0, 0, 1, 1, 0, 0);
    push_one(5, 0); push_one(5, 0); push_one(6, 1);
    run_req("R6 commit multi-destination", 0, 0, 1, 5, 0, 0);
    run_req("R5 commit placeholder", 0, 0, 1, 6, 0, 0);
    run_req("R7 squash on empty", 1, 0, 0, 0, 0, 0);
    run_req("R7 commit on empty", 0, 0, 1, 50, 0, 0);
  endtask

  task automatic t_push_busy();
    push_one(10, 0); push_one(11, 0); push_one(12, 0);
    run_req("R3 squash with push during walk", 1, 10, 0, 0, 1, 40);
    run_req("R3 drain shows push dropped", 0, 0, 1, 100, 0, 0);
  endtask

  task automatic t_priority();
    push_one(20, 0); push_one(21, 0); push_one(22, 0);
    run_req("R8 squash wins over commit", 1, 21, 1, 22, 0, 0);
    run_req("R8 remaining after squash", 0, 0, 1, 100, 0, 0);
  endtask

  task automatic t_full();
    for (int k = 0; k < DEPTH; k++) push_one(30 + k, 0);
    check("R2", "full at DEPTH", int'(full), 1);
    push_one(60, 0);
    check("R2", "full after refused push", int'(full), 1);
    run_req("R2 drain after refused push", 0, 0, 1, 1000, 0, 0);
    @(negedge clk);
    check("R2", "full after drain", int'(full), 0);
  endtask

  initial begin
    rst = 1'b1; push_valid = 0; push_hold = 0; squash_valid = 0; commit_valid = 0;
    push_seq = '0; squash_seq = '0; commit_seq = '0;
    push_arch = '0; push_new = '0; push_prev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_squash_basic();
    t_commit();
    t_push_busy();
    t_priority();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule